// File: doc/BRIEF.md
# Cycle-Counting Interval Timer

This block measures the time between two events by counting cycles of its own reference clock. The event inputs are already synchronous to that clock, and an event is a rising edge: the input sampled high on a clock edge after being sampled low on the edge before. In one-shot mode a rising edge on the start input opens a measurement and a rising edge on the stop input closes it. In period mode the rising edges of the start input alone bound each interval, so a repetitive signal produces one result per period with no gap between measurements.

Each result is the whole number of clock cycles from the opening edge to the closing edge. Any fraction of a cycle is dropped. The result sits in a held output register and is flagged by a one-cycle valid pulse. The counter saturates at all-ones, which sets the full scale to 2^CNT_W - 1 cycles. A batch accumulator adds up a configured number of results, M, after a clear command, so that logic downstream can divide the sum by M and average out the one-cycle quantisation.

Top module: `cyc_interval_timer`

## Requirements
- R1: While reset is low and on the first cycle after it, valid_o, ovf_o and batch_done_o are low and count_o and acc_o are zero.
- R2: In one-shot mode (mode_i = 0), let a start rising edge be sampled on clock edge k and the next stop rising edge on edge k+D. Then valid_o is high after edge k+D and count_o equals D.
- R3: A stop rising edge while no measurement is open is ignored. This includes a stop that rises on the same edge as the opening start. A start rising edge while a one-shot measurement is open is also ignored.
- R4: When D is 2^CNT_W - 1 or more, count_o reports 2^CNT_W - 1 and ovf_o is high together with valid_o. For a shorter D, ovf_o is low.
- R5: valid_o is high for exactly one cycle per result. count_o and ovf_o keep their values until the next result.
- R6: In period mode (mode_i = 1), each start rising edge after the first closes the open interval, reports it as in R2, and opens the next interval on the same edge. stop_i has no effect in this mode.
- R7: A high batch_clr_i on an edge sets acc_o to zero and batch_done_o low after that edge. A result that completes on the same edge is left out of the new batch.
- R8: acc_o is the sum of count_o over the results since the last clear. batch_done_o rises with the M-th result, where M is trials_i and 0 counts as 1. While batch_done_o is high, later results are not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = one-shot start/stop, 1 = period of start_i |
| start_i | input | 1 | Start event level, synchronous to clk |
| stop_i | input | 1 | Stop event level, synchronous to clk |
| trials_i | input | TRIAL_W | Results per batch (M); 0 acts as 1 |
| batch_clr_i | input | 1 | Clears the batch sum and the done flag |
| count_o | output | CNT_W | Last measured interval in clock cycles |
| ovf_o | output | 1 | Last result reached full scale |
| valid_o | output | 1 | One-cycle strobe for a new result |
| acc_o | output | CNT_W+TRIAL_W | Sum of the results in the current batch |
| batch_done_o | output | 1 | M results have been added since the clear |

## Verification
The bench builds the block with CNT_W = 6 and TRIAL_W = 3. With these values full scale is 63 cycles, so intervals of 62, 63 and 70 cycles test both sides of saturation within a short run. A batch holds at most seven results, so a full batch, the results ignored after it, and the zero-means-one batch size all fit in the run. The bench's reference model measures intervals from time stamps rather than from a running counter. It covers a clear on the same edge as a result, ignored start and stop edges, and mode changes while a measurement is open.

// File: rtl/cit_pkg.sv
package cit_pkg;

   typedef enum logic {
      MODE_ONESHOT = 1'b0,
      MODE_PERIOD  = 1'b1
   } cit_mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } cit_state_e;

   localparam int CH_START = 0;
   localparam int CH_STOP  = 1;
   localparam int NUM_CH   = 2;

endpackage

// File: rtl/cit_edge_detect.sv
module cit_edge_detect #(
   parameter int CHANNELS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHANNELS-1:0] level_i,
   output logic [CHANNELS-1:0] rise_o
);

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
      logic prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= level_i[ch];
      end

      assign rise_o[ch] = level_i[ch] & ~prev_q;
   end

endmodule

// File: rtl/cit_span_counter.sv
module cit_span_counter
   import cit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cit_mode_e        mode,
   input  logic             start_ev,
   input  logic             stop_ev,
   output logic             close_o,
   output logic [CNT_W-1:0] span_o,
   output logic             full_o
);

   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   cit_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             open_now, close_now;

   always_comb begin
      open_now  = 1'b0;
      close_now = 1'b0;
      unique case (state_q)
         ST_IDLE: open_now = start_ev;
         ST_RUN: begin
            if (mode == MODE_PERIOD) begin
               close_now = start_ev;
               open_now  = start_ev;
            end else begin
               close_now = stop_ev;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      state_d = state_q;
      if (open_now)       state_d = ST_RUN;
      else if (close_now) state_d = ST_IDLE;
   end

   always_comb begin
      cnt_d = cnt_q;
      if (open_now)                                  cnt_d = ONE;
      else if (state_q == ST_RUN && cnt_q != FULL)   cnt_d = cnt_q + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign close_o = close_now;
   assign span_o  = cnt_q;
   assign full_o  = (cnt_q == FULL);

endmodule

// File: rtl/cit_result_reg.sv
module cit_result_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [CNT_W-1:0] span_i,
   input  logic             full_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o,
   output logic             valid_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_o <= '0;
         ovf_o   <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= fire_i;
         if (fire_i) begin
            count_o <= span_i;
            ovf_o   <= full_i;
         end
      end
   end

endmodule

// File: rtl/cit_trial_accum.sv
module cit_trial_accum #(
   parameter int CNT_W   = 16,
   parameter int TRIAL_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     fire_i,
   input  logic [CNT_W-1:0]         span_i,
   input  logic [TRIAL_W-1:0]       trials_i,
   output logic [CNT_W+TRIAL_W-1:0] acc_o,
   output logic                     done_o
);

   localparam int ACC_W = CNT_W + TRIAL_W;
   localparam int N_W   = TRIAL_W + 1;

   logic [TRIAL_W-1:0] n_q;
   logic [N_W-1:0]     n_inc;
   logic [N_W-1:0]     goal;
   logic               take;

   assign take  = fire_i & ~done_o & ~clr_i;
   assign n_inc = {1'b0, n_q} + N_W'(1);
   assign goal  = (trials_i == '0) ? N_W'(1) : {1'b0, trials_i};

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         acc_o  <= '0;
         n_q    <= '0;
         done_o <= 1'b0;
      end else if (take) begin
         acc_o  <= acc_o + ACC_W'(span_i);
         n_q    <= n_inc[TRIAL_W-1:0];
         done_o <= (n_inc >= goal);
      end
   end

endmodule

// File: rtl/cyc_interval_timer.sv
module cyc_interval_timer
   import cit_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int TRIAL_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_i,
   input  logic                     start_i,
   input  logic                     stop_i,
   input  logic [TRIAL_W-1:0]       trials_i,
   input  logic                     batch_clr_i,
   output logic [CNT_W-1:0]         count_o,
   output logic                     ovf_o,
   output logic                     valid_o,
   output logic [CNT_W+TRIAL_W-1:0] acc_o,
   output logic                     batch_done_o
);

   if (CNT_W < 2 || CNT_W > 48) begin : g_bad_cnt_w
      $error("cyc_interval_timer: CNT_W must lie in 2..48");
   end
   if (TRIAL_W < 1 || TRIAL_W > 16) begin : g_bad_trial_w
      $error("cyc_interval_timer: TRIAL_W must lie in 1..16");
   end

   logic [NUM_CH-1:0] levels, rises;
   logic              close_w, full_w;
   logic [CNT_W-1:0]  span_w;

   assign levels[CH_START] = start_i;
   assign levels[CH_STOP]  = stop_i;

   cit_edge_detect #(.CHANNELS(NUM_CH)) u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (levels),
      .rise_o  (rises)
   );

   cit_span_counter #(.CNT_W(CNT_W)) u_span (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (cit_mode_e'(mode_i)),
      .start_ev (rises[CH_START]),
      .stop_ev  (rises[CH_STOP]),
      .close_o  (close_w),
      .span_o   (span_w),
      .full_o   (full_w)
   );

   cit_result_reg #(.CNT_W(CNT_W)) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (close_w),
      .span_i  (span_w),
      .full_i  (full_w),
      .count_o (count_o),
      .ovf_o   (ovf_o),
      .valid_o (valid_o)
   );

   cit_trial_accum #(.CNT_W(CNT_W), .TRIAL_W(TRIAL_W)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (batch_clr_i),
      .fire_i   (close_w),
      .span_i   (span_w),
      .trials_i (trials_i),
      .acc_o    (acc_o),
      .done_o   (batch_done_o)
   );

endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
   parameter int CNT_W   = 16,
   parameter int TRIAL_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     batch_clr_i,
   input logic [CNT_W-1:0]         count_o,
   input logic                     ovf_o,
   input logic                     valid_o,
   input logic [CNT_W+TRIAL_W-1:0] acc_o,
   input logic                     batch_done_o
);

   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(count_o) && $stable(ovf_o)));

   // R4
   sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (ovf_o == (count_o == FULL)));

   // R2
   nonzero_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (count_o != '0));

   // R7
   batch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      batch_clr_i |=> (acc_o == '0 && !batch_done_o));

   // R8
   batch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (batch_done_o && !batch_clr_i) |=> ($stable(acc_o) && batch_done_o));

   // R8
   done_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(batch_done_o) |-> valid_o);

endmodule

bind cyc_interval_timer cit_checker #(.CNT_W(CNT_W), .TRIAL_W(TRIAL_W)) u_cit_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .batch_clr_i  (batch_clr_i),
   .count_o      (count_o),
   .ovf_o        (ovf_o),
   .valid_o      (valid_o),
   .acc_o        (acc_o),
   .batch_done_o (batch_done_o)
);

// File: tb/cyc_interval_timer_bench.sv
module cyc_interval_timer_bench;

   localparam int CW   = 6;
   localparam int TW   = 3;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          mode_i, start_i, stop_i, batch_clr_i;
   logic [TW-1:0] trials_i;
   logic [CW-1:0] count_o;
   logic          ovf_o, valid_o, batch_done_o;
   logic [CW+TW-1:0] acc_o;

   always #10 clk = ~clk;

   cyc_interval_timer #(.CNT_W(CW), .TRIAL_W(TW)) u_cyc_interval_timer (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
      .stop_i(stop_i), .trials_i(trials_i), .batch_clr_i(batch_clr_i),
      .count_o(count_o), .ovf_o(ovf_o), .valid_o(valid_o),
      .acc_o(acc_o), .batch_done_o(batch_done_o)
   );

   int    n_chk = 0, n_err = 0;
   bit    running = 0, finished = 0;
   string scen = "R5";

   // behavioural reference: time stamps, not a counter
   int  cyc = 0;
   bit  m_open = 0;
   int  m_t0 = 0;
   bit  ps = 0, pp = 0;
   bit  e_valid = 0, e_ovf = 0, e_done = 0, e_period = 0, clr_last = 0;
   int  e_cnt = 0;
   int  e_q[$];

   task automatic report(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic take_result(int d);
      int m;
      e_valid  = 1;
      e_cnt    = (d > MAXC) ? MAXC : d;
      e_ovf    = (d >= MAXC);
      e_period = mode_i;
      m = (trials_i == 0) ? 1 : int'(trials_i);
      if (!batch_clr_i && !e_done) begin
         e_q.push_back(e_cnt);
         if (e_q.size() >= m) e_done = 1;
      end
   endtask

   always @(posedge clk) begin
      bit sr, pr;
      cyc++;
      e_valid = 0;
      clr_last = 0;
      if (!rst_n) begin
         m_open = 0; ps = 0; pp = 0; e_cnt = 0; e_ovf = 0;
         e_done = 0; e_q.delete();
      end else begin
         sr = start_i && !ps;
         pr = stop_i && !pp;
         if (!m_open) begin
            if (sr) begin m_open = 1; m_t0 = cyc; end
         end else if (mode_i) begin
            if (sr) begin take_result(cyc - m_t0); m_t0 = cyc; end
         end else if (pr) begin
            take_result(cyc - m_t0);
            m_open = 0;
         end
         if (batch_clr_i) begin
            e_q.delete(); e_done = 0; clr_last = 1;
         end
         ps = start_i;
         pp = stop_i;
      end
   end

   always @(negedge clk) begin
      int s;
      if (running && rst_n) begin
         s = 0;
         foreach (e_q[i]) s += e_q[i];
         report(scen, valid_o, e_valid);
         report(e_period ? "R6 count" : "R2 count", count_o, e_cnt);
         report("R4 ovf", ovf_o, e_ovf);
         report(clr_last ? "R7 acc" : "R8 acc", acc_o, s);
         report(clr_last ? "R7 done" : "R8 done", batch_done_o, e_done);
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_i = 1; @(negedge clk); start_i = 0;
   endtask

   task automatic clear_batch();
      batch_clr_i = 1; @(negedge clk); batch_clr_i = 0;
   endtask

   task automatic shot(int d);
      start_i = 1; @(negedge clk); start_i = 0;
      wait_n(d - 1);
      stop_i = 1; @(negedge clk); stop_i = 0;
      wait_n(2);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      rst_n = 0; mode_i = 0; start_i = 0; stop_i = 0;
      batch_clr_i = 0; trials_i = 3;
      wait_n(3);
      // R1: state under reset
      report("R1 valid", valid_o, 0);
      report("R1 ovf", ovf_o, 0);
      report("R1 count", count_o, 0);
      report("R1 acc", acc_o, 0);
      report("R1 done", batch_done_o, 0);
      rst_n = 1;
      @(negedge clk);
      // R1: first cycle after reset
      report("R1 valid after", valid_o, 0);
      report("R1 acc after", acc_o, 0);
      running = 1;

      // R2 / R8: batch of three, a fourth result is left out
      clear_batch();
      shot(5); shot(1); shot(12);
      shot(7);

      // R3: ignored stop and start edges
      scen = "R3";
      stop_i = 1; @(negedge clk); stop_i = 0; wait_n(3);
      start_i = 1; stop_i = 1; @(negedge clk); start_i = 0; stop_i = 0;
      wait_n(3);
      pulse_start(); wait_n(2);
      stop_i = 1; @(negedge clk); stop_i = 0; wait_n(3);
      scen = "R5";

      // R4: both sides of saturation
      trials_i = 7;
      clear_batch();
      shot(70); shot(63); shot(62);

      // R6: period mode, stop pulses have no effect
      trials_i = 4;
      clear_batch();
      mode_i = 1;
      pulse_start(); wait_n(3);
      pulse_start(); stop_i = 1; wait_n(2); stop_i = 0; wait_n(4);
      pulse_start(); wait_n(1);
      pulse_start(); stop_i = 1; @(negedge clk); stop_i = 0; wait_n(1);
      pulse_start(); wait_n(1);
      mode_i = 0; wait_n(2);
      stop_i = 1; @(negedge clk); stop_i = 0; wait_n(3);

      // R7: clear on the edge that closes a measurement
      trials_i = 2;
      clear_batch();
      shot(4);
      start_i = 1; @(negedge clk); start_i = 0; wait_n(5);
      stop_i = 1; batch_clr_i = 1; @(negedge clk);
      stop_i = 0; batch_clr_i = 0; wait_n(2);
      shot(9); shot(3);

      // R8: batch size zero behaves as one
      trials_i = 0;
      clear_batch();
      shot(6); shot(8);
      wait_n(3);
      running = 0;
      finish_run();
   end

endmodule